// File: doc/BRIEF.md
# Serial BCD Multiplexed Display Scanner

This block takes a continuous serial stream of BCD codes, one bit per clock, and drives an eight-digit multiplexed segment display from it. It creates all of its frame timing from the bit clock. A divide-by-four counter marks each digit boundary. A one-hot ring walks a single active drive across the eight digit positions. A ninth slot in each frame leaves every drive off.

Each code arrives least-significant bit first. It is gathered in a small shift register and copied to a display latch on the last bit of its slot. It is then decoded into nine segment enables, a through i, for a curved font. Zero is drawn as a half-height glyph and is never blanked, so leading zeros stay visible. A parameter removes the tail segment i for an eight-segment tube.

Top module: `bcd_scan_display`

## Requirements
- R1: While reset is held and before the first clock edge after its release, dig_clk is 0, dig_drv is 8'h01, and seg shows the zero glyph 9'h05C.
- R2: Count clock edges after reset release from 0. dig_clk is high only in the cycle before edge n where n mod 4 = 3, which is the last bit of each slot.
- R3: The slot before edge n is (n/4) mod 9. In slots 0 to 7, dig_drv equals 1 shifted left by the slot number. In slot 8, dig_drv is zero.
- R4: The bit on ser_in at bit position j of a slot (j = n mod 4) becomes bit j of that slot's code, so the first bit is the least-significant one.
- R5: The code received in a slot is shown on seg for all four cycles of the next slot. The code from slot 8 is shown during slot 0 of the next frame.
- R6: seg bit k drives segment k, with a=0, b=1, c=2, d=3, e=4, f=5, g=6, h=7, i=8. The font is 0:05C 1:006 2:05B 3:04F 4:166 5:06D 6:0DD 7:007 8:07F 9:06F (hex).
- R7: Segment f (bit 5) is lit only for codes 4, 5, 8 and 9. Segment i (bit 8) is lit only for code 4.
- R8: Codes 10 to 15 turn off all nine segments.
- R9: A frame of all-zero codes shows the half-height zero glyph on every one of the eight drives, with no blanking of leading zeros.
- R10: With TAIL_SEG = 0, seg bit 8 is always 0 and bits 0 to 7 match the default build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial BCD data, least-significant bit first |
| dig_clk | output | 1 | High during the last bit cycle of each digit slot |
| dig_drv | output | 8 | One-hot digit drive, all zero in the idle slot |
| seg | output | 9 | Segment enables a (bit 0) to i (bit 8) |

## Verification
On the last bit of each slot, three things happen on the same clock edge: the final code bit is shifted in, the code is copied to the display latch, and the drive ring advances. This makes the new glyph and the new drive position appear together. Every slot boundary of a long stream exercises this. The stream holds all sixteen codes in sequence, then random codes. In every cycle, seg and dig_drv are compared with a model that only knows the slot count and the bits it sent. A mismatch of even one cycle between segments and drive is therefore reported.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
   localparam int CODE_W = 4;
   localparam int SEG_W  = 9;
   localparam int TAIL_BIT = 8;
   typedef logic [CODE_W-1:0] code_t;
   typedef logic [SEG_W-1:0]  seg_t;
endpackage

// File: rtl/bcd_scan_divider.sv
module bcd_scan_divider #(
   parameter int RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   generate
      if (RATIO < 2) begin : g_bad_ratio
         $error("bcd_scan_divider: RATIO must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase_q <= '0;
      else if (phase_q == LAST) phase_q <= '0;
      else                      phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/bcd_scan_ring.sv
module bcd_scan_ring #(
   parameter int SLOTS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [SLOTS-1:0] ring
);
   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("bcd_scan_ring: SLOTS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ring <= SLOTS'(1);
      else if (advance) ring <= {ring[SLOTS-2:0], ring[SLOTS-1]};
   end

   p_ring_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ring) == 1);
   p_ring_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ring));
endmodule

// File: rtl/bcd_scan_deser.sv
module bcd_scan_deser
   import bcd_scan_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ser_in,
   input  logic  boundary,
   output code_t code_q
);
   logic [CODE_W-2:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         code_q <= '0;
      end else begin
         hist_q <= {ser_in, hist_q[CODE_W-2:1]};
         if (boundary) code_q <= {ser_in, hist_q};
      end
   end

   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(code_q));
endmodule

// File: rtl/bcd_scan_decode.sv
module bcd_scan_decode
   import bcd_scan_pkg::*;
#(
   parameter bit TAIL_SEG = 1'b1
) (
   input  code_t code,
   output seg_t  seg
);
   logic [SEG_W-2:0] body;

   always_comb begin
      case (code)
         4'd0:    body = 8'h5C;
         4'd1:    body = 8'h06;
         4'd2:    body = 8'h5B;
         4'd3:    body = 8'h4F;
         4'd4:    body = 8'h66;
         4'd5:    body = 8'h6D;
         4'd6:    body = 8'hDD;
         4'd7:    body = 8'h07;
         4'd8:    body = 8'h7F;
         4'd9:    body = 8'h6F;
         default: body = 8'h00;
      endcase
   end

   generate
      if (TAIL_SEG) begin : g_tail
         logic tail;
         assign tail = code[2] & ~(code[0] | code[1] | code[3]);
         assign seg  = {tail, body};
      end else begin : g_no_tail
         assign seg = {1'b0, body};
      end
   endgenerate
endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display
   import bcd_scan_pkg::*;
#(
   parameter int NUM_DIGITS = 8,
   parameter int IDLE_SLOTS = 1,
   parameter bit TAIL_SEG   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_in,
   output logic                  dig_clk,
   output logic [NUM_DIGITS-1:0] dig_drv,
   output logic [SEG_W-1:0]      seg
);
   localparam int SLOTS = NUM_DIGITS + IDLE_SLOTS;

   generate
      if (NUM_DIGITS < 1) begin : g_bad_digits
         $error("bcd_scan_display: NUM_DIGITS must be positive");
      end
      if (IDLE_SLOTS < 0) begin : g_bad_idle
         $error("bcd_scan_display: IDLE_SLOTS must not be negative");
      end
   endgenerate

   logic             boundary;
   logic [SLOTS-1:0] ring;
   code_t            shown;

   bcd_scan_divider #(.RATIO(CODE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(boundary));

   bcd_scan_ring #(.SLOTS(SLOTS)) u_ring (
      .clk(clk), .rst_n(rst_n), .advance(boundary), .ring(ring));

   bcd_scan_deser u_deser (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .boundary(boundary), .code_q(shown));

   bcd_scan_decode #(.TAIL_SEG(TAIL_SEG)) u_dec (
      .code(shown), .seg(seg));

   assign dig_clk = boundary;
   assign dig_drv = ring[NUM_DIGITS-1:0];

   p_seg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dig_clk |=> $stable(seg));
   p_tail_with_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seg[TAIL_BIT] |-> (seg[5] && seg[6] && !seg[0]));
   p_drive_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dig_clk |=> !$stable(ring));
endmodule

// File: tb/bcd_scan_display_tb.sv
module bcd_scan_display_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  FRAMES = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       dig_clk, dig_clk_nt;
   logic [7:0] dig_drv, dig_drv_nt;
   logic [8:0] seg, seg_nt;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_scan_display u_dut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .dig_clk(dig_clk), .dig_drv(dig_drv), .seg(seg));

   bcd_scan_display #(.TAIL_SEG(1'b0)) u_dut_nt (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .dig_clk(dig_clk_nt), .dig_drv(dig_drv_nt), .seg(seg_nt));

   function automatic logic [8:0] font(input logic [3:0] c);
      case (c)
         4'd0: return 9'h05C;
         4'd1: return 9'h006;
         4'd2: return 9'h05B;
         4'd3: return 9'h04F;
         4'd4: return 9'h166;
         4'd5: return 9'h06D;
         4'd6: return 9'h0DD;
         4'd7: return 9'h007;
         4'd8: return 9'h07F;
         4'd9: return 9'h06F;
         default: return 9'h000;
      endcase
   endfunction

   function automatic logic [3:0] code_for(input int g);
      if (g < 9)  return 4'd0;
      if (g < 27) return 4'((g - 9) % 16);
      return 4'($urandom % 16);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int t;
      int bpos;
      int slot;
      logic [3:0] acc;
      logic [3:0] shown;
      logic [3:0] cur;
      logic [8:0] seg_first;
      logic [8:0] exp_seg;
      string tag;
      void'($urandom(32'd1234));
      t = 0;
      acc = '0;
      shown = 4'd0;
      cur = 4'd0;
      seg_first = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state during reset
      check("R1 dig_clk", 32'(dig_clk), 32'd0);
      check("R1 dig_drv", 32'(dig_drv), 32'h01);
      check("R1 seg", 32'(seg), 32'h05C);
      rst_n = 1'b1;
      #1;
      check("R1 seg after release", 32'(seg), 32'h05C);
      while (t < FRAMES * 36) begin
         bpos = t % 4;
         slot = (t / 4) % 9;
         check("R2 dig_clk", 32'(dig_clk), 32'(bpos == 3));
         check("R3 dig_drv", 32'(dig_drv), (slot < 8) ? (32'd1 << slot) : 32'd0);
         exp_seg = font(shown);
         if (t < 40)                      tag = "R9 zero frame";
         else if (shown > 4'd9)           tag = "R8 blank";
         else if (shown == 4'd4 || shown == 4'd5) tag = "R7 f/i";
         else if (shown == 4'd1 || shown == 4'd8) tag = "R4 bit order";
         else                             tag = "R6 font";
         check(tag, 32'(seg), 32'(exp_seg));
         check("R7 f/i rule", 32'({seg[8], seg[5]}),
               32'({shown == 4'd4, shown == 4'd4 || shown == 4'd5 || shown == 4'd8 || shown == 4'd9}));
         check("R10 no tail", 32'(seg_nt), 32'(exp_seg & 9'h0FF));
         if (bpos == 0) seg_first = seg;
         else check("R5 hold in slot", 32'(seg), 32'(seg_first));
         if (bpos == 0) cur = code_for(t / 4);
         ser_in = cur[bpos];
         @(posedge clk);
         acc[bpos] = ser_in;
         if (bpos == 3) shown = acc;
         t++;
         @(negedge clk);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule